// File: doc/BRIEF.md
# Fractional Clock-Enable Generator

This block turns a free-running clock into a stream of enable ticks at a programmed fraction of the clock rate. Two stages produce the fraction. The first is a divider that counts in half clock periods, so it can divide by 1, 1.5, 2, 2.5 and so on. The second is an optional M-out-of-N stage that passes exactly M of every N ticks from the first stage.

The settings arrive in the encodings a configuration register would hold. The divide field `h` gives a tick rate of `2/(h+1)` ticks per clock, and `h = 0` means no division. The N field holds the bitwise inverse of `N - M`. The duty field holds the bitwise inverse of the duty threshold. An update strobe stages a new set of values. The staged values replace the running ones only at the end of a whole divide period that lines up with a clock edge, so a period is never cut short.

A tick that falls halfway through a clock period is flagged on a second output. A level output shows the duty shape of the M/N stage.

Top module: `mnd_tick_gen`

## Requirements
- R1: While `rst_n` is low, all outputs are 0. The running settings reset to `h = 0` and mode 0, so the first clock after reset already produces a tick.
- R2: With `h = 0` and the M/N stage inactive, `tick_o` is 1 in every cycle and `tick_mid_o` stays 0.
- R3: With `h >= 1`, an event occurs after every `h+1` half clock periods, counted from the last applied update. This gives exactly 2 events in every `h+1` cycles.
- R4: `tick_mid_o` is 1 only together with `tick_o`. It marks a tick whose event fell at the midpoint of the cycle (the first half-slot) rather than at the clock edge. With `h = 2` every second tick is a midpoint tick.
- R5: The effective N is `(~n_i & mask) + m_i`, where `mask = 2^MNW - 1`.
- R6: The M/N stage is active when all three of these hold: `mode_i != 0`, `m_i != 0` and `(~n_i & mask) != 0`. When it is active, an accumulator starting at 0 adds M on each divider event. A tick is emitted on each event where the sum reaches N, and N is then subtracted. This gives exactly M ticks per N events.
- R7: When the M/N stage is inactive, every divider event passes straight to `tick_o`. This covers mode 0, M = 0, and M = N (a stored N field of all ones).
- R8: When the M/N stage is active, `lvl_o` is 1 when the accumulator value after this cycle is below `~d_i & mask`. When the stage is inactive, `lvl_o` equals `tick_o`.
- R9: A pulse on `upd_i` captures the inputs. They take effect after the first cycle whose half-period count ends exactly at zero on a clock edge. Until then the old settings keep running. On taking effect, both counters restart from 0.
- R10: If `upd_i` pulses more than once before the boundary, the last captured values are the ones applied.
- R11: Outputs are registered. The outputs seen after a clock edge describe the events of the cycle that edge ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Stage new settings |
| hdiv_i | input | HW | Half-period divide field h |
| mode_i | input | 2 | Nonzero enables the M/N stage |
| m_i | input | MNW | M value |
| n_i | input | MNW | Inverse of N minus M |
| d_i | input | MNW | Inverse of duty threshold |
| tick_o | output | 1 | Output enable tick |
| tick_mid_o | output | 1 | Tick event fell mid-cycle |
| lvl_o | output | 1 | Duty level of the M/N stage |

## Verification
The corner cases the bench targets are these:

- Odd half-period counts (h even), where events alternate between the midpoint and the edge. A divider that counted whole cycles would drop every midpoint tick, or report it on the wrong cycle.
- The N decoding. A design that used the stored N field without inverting it, or without adding M back, would pass the wrong number of ticks per window.
- The M = N and mode-0 cases. These must pass every event through; a design that got this wrong would lose ticks to a degenerate accumulator.
- Updates issued mid-period and updates issued twice before the boundary. A design that applied the values at once would emit a runt tick early, and one that latched the first pulse would run at a stale rate.

// File: rtl/mnd_tick_gen.sv
module mnd_tick_gen #(
  parameter int HW  = 5,
  parameter int MNW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_i,
  input  logic [HW-1:0]  hdiv_i,
  input  logic [1:0]     mode_i,
  input  logic [MNW-1:0] m_i,
  input  logic [MNW-1:0] n_i,
  input  logic [MNW-1:0] d_i,
  output logic           tick_o,
  output logic           tick_mid_o,
  output logic           lvl_o
);
  localparam int CW = HW + 1;
  localparam int AW = MNW + 2;

  logic [HW-1:0]  h_q, h_p;
  logic [1:0]     mode_q, mode_p;
  logic [MNW-1:0] m_q, m_p, n_q, n_p, d_q, d_p;
  logic           pend_q;

  logic [CW-1:0]  cnt_q, lim, c0, c1;
  logic [AW-1:0]  acc_q, acc_n, sum, n_eff;
  logic [MNW-1:0] n_diff, d_eff;
  logic           ev, mid, mn_on, wrap, out_ev, bnd, apply;

  assign lim    = CW'(h_q) + CW'(1);
  assign n_diff = ~n_q;
  assign d_eff  = ~d_q;
  assign n_eff  = AW'(n_diff) + AW'(m_q);
  assign mn_on  = (mode_q != 2'd0) && (m_q != '0) && (n_diff != '0);

  always_comb begin
    ev  = 1'b0;
    mid = 1'b0;
    c0  = '0;
    c1  = '0;
    if (h_q != '0) begin
      c0 = cnt_q + CW'(1);
      if (c0 == lim) begin
        ev  = 1'b1;
        mid = 1'b1;
        c0  = '0;
      end
      c1 = c0 + CW'(1);
      if (c1 == lim) begin
        ev = 1'b1;
        c1 = '0;
      end
    end else begin
      ev = 1'b1;
    end
  end

  assign sum    = acc_q + AW'(m_q);
  assign wrap   = sum >= n_eff;
  assign out_ev = mn_on ? (ev && wrap) : ev;
  assign acc_n  = (mn_on && ev) ? (wrap ? sum - n_eff : sum) : acc_q;
  assign bnd    = (c1 == '0);
  assign apply  = pend_q && bnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q <= '0; mode_q <= '0; m_q <= '0; n_q <= '0; d_q <= '0;
      h_p <= '0; mode_p <= '0; m_p <= '0; n_p <= '0; d_p <= '0;
      pend_q     <= 1'b0;
      cnt_q      <= '0;
      acc_q      <= '0;
      tick_o     <= 1'b0;
      tick_mid_o <= 1'b0;
      lvl_o      <= 1'b0;
    end else begin
      cnt_q      <= c1;
      acc_q      <= apply ? '0 : acc_n;
      tick_o     <= out_ev;
      tick_mid_o <= out_ev && mid;
      lvl_o      <= mn_on ? (acc_n < AW'(d_eff)) : out_ev;
      if (apply) begin
        h_q <= h_p; mode_q <= mode_p; m_q <= m_p; n_q <= n_p; d_q <= d_p;
        pend_q <= 1'b0;
      end
      if (upd_i) begin
        h_p <= hdiv_i; mode_p <= mode_i; m_p <= m_i; n_p <= n_i; d_p <= d_i;
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mnd_tick_gen_chk.sv
module mnd_tick_gen_chk #(
  parameter int HW  = 5,
  parameter int MNW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_o,
  input logic            tick_mid_o,
  input logic [HW-1:0]   h_q,
  input logic [HW:0]     cnt_q,
  input logic [MNW+1:0]  acc_q,
  input logic [MNW+1:0]  n_eff,
  input logic            mn_on
);
  assert_mid_has_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_mid_o |-> tick_o);

  assert_no_double_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_mid_o |=> !tick_mid_o);

  assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (HW+1)'(h_q));

  assert_acc_below_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mn_on |-> (acc_q < n_eff));

  assert_cfg_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(h_q) |-> (cnt_q == '0 && acc_q == '0));

  assert_bypass_each_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q == '0 && !mn_on) |=> tick_o);
endmodule

bind mnd_tick_gen mnd_tick_gen_chk #(.HW(HW), .MNW(MNW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_o(tick_o), .tick_mid_o(tick_mid_o),
  .h_q(h_q), .cnt_q(cnt_q), .acc_q(acc_q), .n_eff(n_eff), .mn_on(mn_on)
);

// File: tb/test_mnd_tick_gen.sv
`timescale 1ns/1ps
module test_mnd_tick_gen;
  localparam int HW   = 5;
  localparam int MNW  = 8;
  localparam int MASK = (1 << MNW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic [HW-1:0] hdiv = '0;
  logic [1:0] mode = '0;
  logic [MNW-1:0] mv = '0, nv = '0, dv = '0;
  logic tick, tick_mid, lvl;

  always #5 clk = ~clk;

  mnd_tick_gen #(.HW(HW), .MNW(MNW)) i_mnd_tick_gen (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .hdiv_i(hdiv), .mode_i(mode),
    .m_i(mv), .n_i(nv), .d_i(dv), .tick_o(tick), .tick_mid_o(tick_mid), .lvl_o(lvl)
  );

  int total = 0, bad = 0;
  int a_h = 0, a_mode = 0, a_m = 0, a_n = 0, a_d = 0;
  int p_h = 0, p_mode = 0, p_m = 0, p_n = 0, p_d = 0, ppend = 0;
  int mc = 0, macc = 0;
  logic exp_tick = 0, exp_mid = 0, exp_lvl = 0;
  string exp_tag = "R1";

  always @(posedge clk) begin
    int ev, mid, ndiff, neff, deff, mnon, tk, accn;
    if (!rst_n) begin
      a_h = 0; a_mode = 0; a_m = 0; a_n = 0; a_d = 0;
      p_h = 0; p_mode = 0; p_m = 0; p_n = 0; p_d = 0; ppend = 0;
      mc = 0; macc = 0;
      exp_tick = 0; exp_mid = 0; exp_lvl = 0; exp_tag = "R1";
    end else begin
      ndiff = (~a_n) & MASK;
      neff  = ndiff + a_m;
      deff  = (~a_d) & MASK;
      mnon  = (a_mode != 0 && a_m != 0 && ndiff != 0) ? 1 : 0;
      ev = 0; mid = 0;
      if (a_h == 0) ev = 1;
      else begin
        for (int s = 0; s < 2; s++) begin
          mc = mc + 1;
          if (mc == a_h + 1) begin
            ev = 1;
            if (s == 0) mid = 1;
            mc = 0;
          end
        end
      end
      tk = ev; accn = macc;
      if (mnon != 0 && ev != 0) begin
        accn = macc + a_m;
        tk = 0;
        if (accn >= neff) begin accn = accn - neff; tk = 1; end
      end
      exp_tick = (tk != 0);
      exp_mid  = (tk != 0 && mid != 0);
      exp_lvl  = (mnon != 0) ? (accn < deff) : (tk != 0);
      exp_tag  = (mnon != 0) ? "R6" : ((a_h == 0) ? "R2" : "R3");
      macc = accn;
      if (ppend != 0 && mc == 0) begin
        a_h = p_h; a_mode = p_mode; a_m = p_m; a_n = p_n; a_d = p_d;
        macc = 0; ppend = 0;
      end
      if (upd) begin
        p_h = hdiv; p_mode = mode; p_m = mv; p_n = nv; p_d = dv; ppend = 1;
      end
    end
  end

  always @(negedge clk) begin
    total++;
    if (tick !== exp_tick) begin
      bad++;
      $display("FAIL %s tick_o actual=%b expected=%b at %0t", exp_tag, tick, exp_tick, $time);
    end
    total++;
    if (tick_mid !== exp_mid) begin
      bad++;
      $display("FAIL R4 tick_mid_o actual=%b expected=%b at %0t", tick_mid, exp_mid, $time);
    end
    total++;
    if (lvl !== exp_lvl) begin
      bad++;
      $display("FAIL R8 lvl_o actual=%b expected=%b at %0t", lvl, exp_lvl, $time);
    end
  end

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic stage(input int h, input int md, input int m, input int n, input int d);
    @(negedge clk); #1;
    hdiv = HW'(h); mode = 2'(md); mv = MNW'(m); nv = MNW'(n); dv = MNW'(d);
    upd = 1'b1;
    @(posedge clk); #1;
    upd = 1'b0;
  endtask

  task automatic wait_apply();
    @(negedge clk); #1;
    while (ppend != 0) begin @(negedge clk); #1; end
  endtask

  task automatic count(input int n, output int nt, output int nm, output int nl);
    nt = 0; nm = 0; nl = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (tick) nt++;
      if (tick_mid) nm++;
      if (lvl) nl++;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int nt, nm, nl;
    repeat (4) @(negedge clk);
    #1;
    check("R1 outputs low in reset", int'(tick) + int'(tick_mid) + int'(lvl), 0);
    rst_n = 1'b1;
    count(10, nt, nm, nl);
    check("R1 default bypass after reset", nt, 10);
    check("R2 no mid ticks in bypass", nm, 0);

    stage(1, 0, 0, 0, 0); wait_apply();
    count(20, nt, nm, nl);
    check("R3 h=1 rate", nt, 20);

    stage(2, 0, 0, 0, 0); wait_apply();
    count(30, nt, nm, nl);
    check("R3 h=2 rate", nt, 20);
    check("R4 h=2 midpoint ticks", nm, 10);

    stage(6, 0, 0, 0, 0); wait_apply();
    count(35, nt, nm, nl);
    check("R3 h=6 rate", nt, 10);

    stage(0, 1, 3, (~5) & MASK, (~4) & MASK); wait_apply();
    count(80, nt, nm, nl);
    check("R6 M/N 3 of 8", nt, 30);

    stage(4, 1, 2, (~3) & MASK, (~0) & MASK); wait_apply();
    count(50, nt, nm, nl);
    check("R5 N decode with h=4", nt, 8);

    stage(0, 2, 1, (~3) & MASK, (~2) & MASK); wait_apply();
    count(8, nt, nm, nl);
    check("R8 duty level count", nl, 4);
    check("R6 M/N 1 of 4", nt, 2);

    stage(0, 1, 5, MASK, 0); wait_apply();
    count(20, nt, nm, nl);
    check("R7 M equals N passes through", nt, 20);

    stage(0, 0, 3, (~5) & MASK, 0); wait_apply();
    count(20, nt, nm, nl);
    check("R7 mode 0 passes through", nt, 20);

    stage(9, 0, 0, 0, 0); wait_apply();
    nt = 0;
    while (!tick) begin @(negedge clk); #1; end
    hdiv = '0; mode = '0; upd = 1'b1;
    @(posedge clk); #1;
    upd = 1'b0;
    count(4, nt, nm, nl);
    check("R9 old period completes before apply", nt, 0);
    count(5, nt, nm, nl);
    check("R9 new settings after boundary", nt, 5);

    stage(15, 0, 0, 0, 0); wait_apply();
    stage(3, 0, 0, 0, 0);
    stage(0, 0, 0, 0, 0);
    wait_apply();
    count(10, nt, nm, nl);
    check("R10 last staged values win", nt, 10);

    rst_n = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    check("R1 reset mid-run clears outputs", int'(tick) + int'(lvl), 0);
    rst_n = 1'b1;
    count(5, nt, nm, nl);
    check("R11 registered bypass after reset", nt, 5);

    finish_run();
  end
endmodule